// File: doc/BRIEF.md
# Tape Controller Command and Status Unit

This block is the command side of a nine-track tape controller. The host writes an 8-bit function code on a strobed bus. The unit checks the code against the eight operation codes and against the current unit state. If the code passes, the unit latches it, reports busy and arms a fixed start delay. When the delay runs out, it pulses a start signal to the transfer sequencer. A code that fails the checks raises a reject bit and starts nothing. A separate clear code puts the controller back into a quiet state. If a rewind is running, the clear code also aborts it.

The unit keeps a 9-bit status word. Six of its bits are stored. Three are live: local, write-locked and busy, which come from the unit's attached and write-lock inputs and from the unit's own activity. The unit also holds a control flip-flop, a flag, a flag buffer and a service request for each of two channels: channel 0 is the command channel and channel 1 is the data channel. All of these reset to clear. When the sequencer signals that an operation is complete, the unit sets the command flag, drops busy, and merges the sequencer's outcome bits into the stored status.

Top module: `tape_cmd_unit`

## Requirements
- R1: A synchronous reset clears every control, flag, flag-buffer and service-request flip-flop, the latched function, the first-service and transfer-enable outputs and all stored status bits. The one exception is the beginning-of-tape bit, which is loaded with `unit_at_bot` when `unit_attached` is high.
- R2: `status_word` bit positions are local=8, end-of-file=7, beginning-of-tape=6, end-of-tape=5, timing=4, reject=3, write-locked=2, parity=1, busy=0. When the unit is attached, bit 8 is 0, bit 2 follows `unit_wlock` and bit 0 shows that an operation is in progress. When the unit is not attached, bits 8 and 0 read 1 and bit 2 reads 0.
- R3: Every host write first clears the reject bit. A non-clear code then sets the reject bit and starts nothing if any of these holds: the code is not one of 031, 023, 011, 003, 041, 201, 101, 035 (octal); an operation is in progress; the code is 041 while the stored beginning-of-tape bit is set; or the code is 031, 011 or 035 while `unit_wlock` is high.
- R4: An accepted code has these effects. It is latched on `func_q`. The stored status becomes all zero, so the word reads busy only. Both channel flags are cleared. `first_svc` and `xfer_en` are set. `ptr_reset` pulses for one cycle after the accepting edge.
- R5: `op_go` is a one-cycle pulse in the CMD_DELAY-th cycle, counting the cycle that follows the accepting edge as cycle 1. With the default, this is cycle 40. It is only raised while the unit is attached.
- R6: Code 300 (octal) clears `first_svc`, `xfer_en`, both control flip-flops and both flags. Of the stored status, it keeps only the beginning-of-tape bit. It is never rejected.
- R7: Code 300 aborts a rewind (201) or rewind-and-offline (101) that is in progress. Busy drops and `op_go` never follows. Any other operation in progress stays busy.
- R8: A `seq_done` pulse, taken while an operation is in progress and the delay has expired, has these effects. It clears busy and loads the beginning-of-tape bit from `unit_at_bot`. It ORs `seq_done_sts` = {end-of-file, end-of-tape, timing, parity} into the stored status. It sets the command flag, except when the latched function is 101.
- R9: If the delay expires while the unit is not attached, there is no `op_go`. The operation ends, the reject bit is set and the command flag is set.
- R10: `host_ctl_set` and `host_ctl_clr` set and clear the control flip-flops of each channel, with clear winning. `host_ctl_clr[1]` also clears `xfer_en`. `seq_dflag_set` sets the data flag. `host_flg_clr` clears the flags. The flag buffers are set and cleared with their flags, and `srq_q` always equals `flg_q`.
- R11: `seq_first_clr` clears `first_svc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Function-code write strobe |
| host_data | input | 8 | Function code |
| host_ctl_set | input | 2 | Set control flip-flop, one bit per channel |
| host_ctl_clr | input | 2 | Clear control flip-flop, one bit per channel |
| host_flg_clr | input | 2 | Clear flag, one bit per channel |
| seq_done | input | 1 | Operation-complete pulse from the sequencer |
| seq_done_sts | input | 4 | Outcome bits {eof, eot, timing, parity} |
| seq_dflag_set | input | 1 | Set the data-channel flag |
| seq_first_clr | input | 1 | Clear the first-service flip-flop |
| unit_attached | input | 1 | Tape unit is online |
| unit_wlock | input | 1 | Tape unit is write-locked |
| unit_at_bot | input | 1 | Tape is at the beginning |
| status_word | output | 9 | Status read port |
| func_q | output | 8 | Latched function code |
| op_go | output | 1 | Start pulse after the command delay |
| ptr_reset | output | 1 | Buffer-pointer reset pulse |
| first_svc | output | 1 | First-service flip-flop |
| xfer_en | output | 1 | Data-transfer flip-flop |
| ctl_q | output | 2 | Control flip-flops {data, command} |
| flg_q | output | 2 | Flags {data, command} |
| fbf_q | output | 2 | Flag buffers {data, command} |
| srq_q | output | 2 | Service requests {data, command} |

## Verification
The assertions check these properties on every cycle:
- a write to a busy unit is rejected;
- a command that passes the checks leaves the word at busy-only with both flags down;
- the clear code leaves the flops and the stored error bits at zero;
- `op_go` is a single-cycle pulse that comes only while busy;
- an unattached unit reads local and busy;
- completing a rewind-and-offline never raises the command flag.

Other behaviours can only be shown by the bench's scenarios:
- the exact 40-cycle start delay;
- the rule against backward space at beginning of tape;
- the write-lock rejects for the three write codes;
- the merge of outcome bits;
- a rewind aborted with no later start pulse, set against a forward space that survives the clear code;
- the timeout path when the unit goes offline during the delay.

// File: rtl/tape_cmd_pkg.sv
package tape_cmd_pkg;

    localparam logic [7:0] FN_CLEAR  = 8'o300;
    localparam logic [7:0] FN_WRITE  = 8'o031;
    localparam logic [7:0] FN_READ   = 8'o023;
    localparam logic [7:0] FN_GAP    = 8'o011;
    localparam logic [7:0] FN_FWD    = 8'o003;
    localparam logic [7:0] FN_BACK   = 8'o041;
    localparam logic [7:0] FN_REWIND = 8'o201;
    localparam logic [7:0] FN_RWOFF  = 8'o101;
    localparam logic [7:0] FN_MARK   = 8'o035;

    localparam int NUM_CHAN = 2;
    localparam int CH_CMD   = 0;
    localparam int CH_DAT   = 1;

    // Stored part of the status word
    typedef struct packed {
        logic eof;
        logic bot;
        logic eot;
        logic tim;
        logic rej;
        logic par;
    } stored_sts_t;

    // Outcome bits delivered with a completion pulse
    typedef struct packed {
        logic eof;
        logic eot;
        logic tim;
        logic par;
    } done_sts_t;

    typedef enum logic [1:0] {
        DEC_NONE   = 2'd0,
        DEC_CLEAR  = 2'd1,
        DEC_ACCEPT = 2'd2,
        DEC_REJECT = 2'd3
    } dec_result_t;

    function automatic logic is_operation(input logic [7:0] code);
        case (code)
            FN_WRITE, FN_READ, FN_GAP, FN_FWD,
            FN_BACK, FN_REWIND, FN_RWOFF, FN_MARK: return 1'b1;
            default:                               return 1'b0;
        endcase
    endfunction

    function automatic logic writes_tape(input logic [7:0] code);
        return (code == FN_WRITE) || (code == FN_GAP) || (code == FN_MARK);
    endfunction

    function automatic logic is_rewind(input logic [7:0] code);
        return (code == FN_REWIND) || (code == FN_RWOFF);
    endfunction

    function automatic logic [8:0] build_status(input stored_sts_t s,
                                                input logic attached,
                                                input logic wlock,
                                                input logic active);
        logic local_b, wlk_b, busy_b;
        local_b = ~attached;
        wlk_b   = attached & wlock;
        busy_b  = ~attached | active;
        return {local_b, s.eof, s.bot, s.eot, s.tim, s.rej, wlk_b, s.par, busy_b};
    endfunction

endpackage

// File: rtl/tape_cmd_decode.sv
module tape_cmd_decode
    import tape_cmd_pkg::*;
(
    input  logic        wr,
    input  logic [7:0]  code,
    input  logic        active,
    input  logic        stored_bot,
    input  logic        wlock,
    output dec_result_t result
);
    logic bad_code, busy_hit, bot_hit, lock_hit;

    always_comb begin
        bad_code = ~is_operation(code);
        busy_hit = active;
        bot_hit  = (code == FN_BACK) & stored_bot;
        lock_hit = wlock & writes_tape(code);
        if (!wr)
            result = DEC_NONE;
        else if (code == FN_CLEAR)
            result = DEC_CLEAR;
        else if (bad_code | busy_hit | bot_hit | lock_hit)
            result = DEC_REJECT;
        else
            result = DEC_ACCEPT;
    end
endmodule

// File: rtl/tape_cmd_timer.sv
module tape_cmd_timer #(
    parameter int CMD_DELAY = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic abort,
    output logic running,
    output logic expire
);
    localparam int CW = $clog2(CMD_DELAY + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(CMD_DELAY);

    logic [CW-1:0] cnt;

    assign running = (cnt != '0);
    assign expire  = (cnt == CW'(1));

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (abort)
            cnt <= '0;
        else if (load)
            cnt <= LOAD_VAL;
        else if (running)
            cnt <= cnt - CW'(1);
    end
endmodule

// File: rtl/tape_chan_flops.sv
module tape_chan_flops (
    input  logic clk,
    input  logic rst,
    input  logic ctl_set,
    input  logic ctl_clr,
    input  logic flg_set,
    input  logic flg_clr,
    output logic ctl,
    output logic flg,
    output logic fbf,
    output logic srq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= 1'b0;
            flg <= 1'b0;
            fbf <= 1'b0;
        end else begin
            if (ctl_clr)      ctl <= 1'b0;
            else if (ctl_set) ctl <= 1'b1;
            if (flg_clr) begin
                flg <= 1'b0;
                fbf <= 1'b0;
            end else if (flg_set) begin
                flg <= 1'b1;
                fbf <= 1'b1;
            end
        end
    end

    assign srq = flg;
endmodule

// File: rtl/tape_status_reg.sv
module tape_status_reg
    import tape_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        reset_bot,
    input  logic        any_write,
    input  dec_result_t dec,
    input  logic        done_evt,
    input  done_sts_t   done_sts,
    input  logic        live_bot,
    input  logic        fail_evt,
    output stored_sts_t sts
);
    stored_sts_t nxt;

    always_comb begin
        nxt = sts;
        if (done_evt) begin
            nxt.eof = sts.eof | done_sts.eof;
            nxt.eot = sts.eot | done_sts.eot;
            nxt.tim = sts.tim | done_sts.tim;
            nxt.par = sts.par | done_sts.par;
            nxt.bot = live_bot;
        end
        if (fail_evt)
            nxt.rej = 1'b1;
        if (any_write)
            nxt.rej = 1'b0;
        case (dec)
            DEC_CLEAR: begin
                nxt     = '0;
                nxt.bot = sts.bot;
            end
            DEC_ACCEPT: nxt = '0;
            DEC_REJECT: nxt.rej = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts     <= '0;
            sts.bot <= reset_bot;
        end else begin
            sts <= nxt;
        end
    end
endmodule

// File: rtl/tape_cmd_unit.sv
module tape_cmd_unit
    import tape_cmd_pkg::*;
#(
    parameter int CMD_DELAY = 40
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [7:0] host_data,
    input  logic [1:0] host_ctl_set,
    input  logic [1:0] host_ctl_clr,
    input  logic [1:0] host_flg_clr,
    input  logic       seq_done,
    input  logic [3:0] seq_done_sts,
    input  logic       seq_dflag_set,
    input  logic       seq_first_clr,
    input  logic       unit_attached,
    input  logic       unit_wlock,
    input  logic       unit_at_bot,
    output logic [8:0] status_word,
    output logic [7:0] func_q,
    output logic       op_go,
    output logic       ptr_reset,
    output logic       first_svc,
    output logic       xfer_en,
    output logic [1:0] ctl_q,
    output logic [1:0] flg_q,
    output logic [1:0] fbf_q,
    output logic [1:0] srq_q
);
    dec_result_t dec;
    stored_sts_t sts;
    logic        active;
    logic        tmr_running, tmr_expire;
    logic        is_clr, is_acc;
    logic        rew_abort, done_evt, fail_evt, done_flag;
    logic [1:0]  flg_set_v, flg_clr_v, ctl_clr_v;

    tape_cmd_decode u_decode (
        .wr         (host_wr),
        .code       (host_data),
        .active     (active),
        .stored_bot (sts.bot),
        .wlock      (unit_wlock),
        .result     (dec)
    );

    assign is_clr    = (dec == DEC_CLEAR);
    assign is_acc    = (dec == DEC_ACCEPT);
    assign rew_abort = is_clr & active & is_rewind(func_q);
    assign done_evt  = seq_done & active & ~tmr_running;
    assign fail_evt  = tmr_expire & ~unit_attached;
    assign done_flag = done_evt & (func_q != FN_RWOFF);
    assign op_go     = tmr_expire & unit_attached;

    tape_cmd_timer #(.CMD_DELAY(CMD_DELAY)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .load    (is_acc),
        .abort   (rew_abort),
        .running (tmr_running),
        .expire  (tmr_expire)
    );

    tape_status_reg u_status (
        .clk       (clk),
        .rst       (rst),
        .reset_bot (unit_attached & unit_at_bot),
        .any_write (host_wr),
        .dec       (dec),
        .done_evt  (done_evt),
        .done_sts  (done_sts_t'(seq_done_sts)),
        .live_bot  (unit_at_bot),
        .fail_evt  (fail_evt),
        .sts       (sts)
    );

    assign flg_set_v[CH_CMD] = done_flag | fail_evt;
    assign flg_set_v[CH_DAT] = seq_dflag_set;

    generate
        for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
            assign flg_clr_v[ch] = host_flg_clr[ch] | is_clr | is_acc;
            assign ctl_clr_v[ch] = host_ctl_clr[ch] | is_clr;
            tape_chan_flops u_flops (
                .clk     (clk),
                .rst     (rst),
                .ctl_set (host_ctl_set[ch]),
                .ctl_clr (ctl_clr_v[ch]),
                .flg_set (flg_set_v[ch]),
                .flg_clr (flg_clr_v[ch]),
                .ctl     (ctl_q[ch]),
                .flg     (flg_q[ch]),
                .fbf     (fbf_q[ch]),
                .srq     (srq_q[ch])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            active    <= 1'b0;
            func_q    <= '0;
            first_svc <= 1'b0;
            xfer_en   <= 1'b0;
            ptr_reset <= 1'b0;
        end else begin
            ptr_reset <= is_acc;
            if (is_acc) begin
                active <= 1'b1;
                func_q <= host_data;
            end else if (done_evt | fail_evt | rew_abort) begin
                active <= 1'b0;
            end
            if (is_clr | seq_first_clr) first_svc <= 1'b0;
            else if (is_acc)            first_svc <= 1'b1;
            if (is_clr | host_ctl_clr[CH_DAT]) xfer_en <= 1'b0;
            else if (is_acc)                   xfer_en <= 1'b1;
        end
    end

    assign status_word = build_status(sts, unit_attached, unit_wlock, active);
endmodule

// File: rtl/tape_cmd_unit_chk.sv
module tape_cmd_unit_chk
    import tape_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       host_wr,
    input logic [7:0] host_data,
    input logic       seq_done,
    input logic       unit_attached,
    input logic       unit_wlock,
    input logic [8:0] status_word,
    input logic [7:0] func_q,
    input logic       op_go,
    input logic       first_svc,
    input logic       xfer_en,
    input logic [1:0] ctl_q,
    input logic [1:0] flg_q
);
    logic acc_ok;
    assign acc_ok = host_wr && is_operation(host_data) && unit_attached &&
                    !status_word[0] &&
                    !((host_data == FN_BACK) && status_word[6]) &&
                    !(unit_wlock && writes_tape(host_data));

    AST_REJECT_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_data != FN_CLEAR && unit_attached && status_word[0])
        |=> status_word[3]); // R3

    AST_ACCEPT_BUSY_ONLY: assert property (@(posedge clk) disable iff (rst)
        acc_ok |=> (status_word[0] && !status_word[3] && flg_q == 2'b00
                    && first_svc && xfer_en)); // R4

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (rst)
        op_go |=> !op_go); // R5

    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        op_go |-> status_word[0]); // R5

    AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_data == FN_CLEAR) |=>
        (ctl_q == 2'b00 && flg_q == 2'b00 && !xfer_en && !first_svc &&
         !status_word[7] && status_word[5:3] == 3'b000 && !status_word[1])); // R6

    AST_OFFLINE_READS: assert property (@(posedge clk) disable iff (rst)
        !unit_attached |-> (status_word[8] && status_word[0] && !status_word[2])); // R2

    AST_RWOFF_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        (seq_done && func_q == FN_RWOFF && unit_attached && !flg_q[0] && !host_wr)
        |=> !flg_q[0]); // R8
endmodule

bind tape_cmd_unit tape_cmd_unit_chk i_chk (
    .clk           (clk),
    .rst           (rst),
    .host_wr       (host_wr),
    .host_data     (host_data),
    .seq_done      (seq_done),
    .unit_attached (unit_attached),
    .unit_wlock    (unit_wlock),
    .status_word   (status_word),
    .func_q        (func_q),
    .op_go         (op_go),
    .first_svc     (first_svc),
    .xfer_en       (xfer_en),
    .ctl_q         (ctl_q),
    .flg_q         (flg_q)
);

// File: tb/test_tape_cmd_unit.sv
module test_tape_cmd_unit;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic [1:0] host_ctl_set = '0;
    logic [1:0] host_ctl_clr = '0;
    logic [1:0] host_flg_clr = '0;
    logic       seq_done = 1'b0;
    logic [3:0] seq_done_sts = '0;
    logic       seq_dflag_set = 1'b0;
    logic       seq_first_clr = 1'b0;
    logic       unit_attached = 1'b1;
    logic       unit_wlock = 1'b0;
    logic       unit_at_bot = 1'b1;
    logic [8:0] status_word;
    logic [7:0] func_q;
    logic       op_go, ptr_reset, first_svc, xfer_en;
    logic [1:0] ctl_q, flg_q, fbf_q, srq_q;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    tape_cmd_unit i_tape_cmd_unit (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_data(host_data),
        .host_ctl_set(host_ctl_set), .host_ctl_clr(host_ctl_clr),
        .host_flg_clr(host_flg_clr), .seq_done(seq_done),
        .seq_done_sts(seq_done_sts), .seq_dflag_set(seq_dflag_set),
        .seq_first_clr(seq_first_clr), .unit_attached(unit_attached),
        .unit_wlock(unit_wlock), .unit_at_bot(unit_at_bot),
        .status_word(status_word), .func_q(func_q), .op_go(op_go),
        .ptr_reset(ptr_reset), .first_svc(first_svc), .xfer_en(xfer_en),
        .ctl_q(ctl_q), .flg_q(flg_q), .fbf_q(fbf_q), .srq_q(srq_q)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic put_code(input logic [7:0] code);
        @(negedge clk);
        host_wr = 1'b1;
        host_data = code;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse_done(input logic [3:0] sts);
        @(negedge clk);
        seq_done = 1'b1;
        seq_done_sts = sts;
        @(negedge clk);
        seq_done = 1'b0;
        seq_done_sts = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Called right after put_code: cycle 1 is the one after the accepting edge
    task automatic go_cycle(output int k);
        k = 1;
        while (!op_go && k < 100) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic count_go(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (op_go) hits++;
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
        chk("R1 status after reset", status_word, 9'o100);
        chk("R1 ctl after reset", ctl_q, 0);
        chk("R1 flg after reset", flg_q, 0);
        chk("R1 fbf after reset", fbf_q, 0);
        chk("R1 srq after reset", srq_q, 0);
        chk("R1 func after reset", func_q, 0);
        chk("R1 first/xfer after reset", {first_svc, xfer_en}, 0);
    endtask

    task automatic t_invalid;
        put_code(8'o077);
        chk("R3 invalid code rejected", status_word, 9'o110);
        chk("R3 invalid code leaves func", func_q, 0);
        chk("R3 invalid code no first", first_svc, 0);
    endtask

    task automatic t_accept_read;
        int k;
        put_code(8'o023);
        chk("R4 accept busy only", status_word, 9'o001);
        chk("R4 accept func", func_q, 8'o023);
        chk("R4 accept first/xfer", {first_svc, xfer_en}, 3);
        chk("R4 ptr_reset pulse", ptr_reset, 1);
        go_cycle(k);
        chk("R5 op_go cycle", k, 40);
        @(negedge clk);
        chk("R5 op_go one cycle", op_go, 0);
        chk("R4 ptr_reset one cycle", ptr_reset, 0);
        put_code(8'o003);
        chk("R3 busy reject", status_word, 9'o011);
        chk("R3 busy reject keeps func", func_q, 8'o023);
        // channel flops
        @(negedge clk); seq_dflag_set = 1'b1;
        @(negedge clk); seq_dflag_set = 1'b0;
        chk("R10 data flag set", flg_q, 2);
        chk("R10 data fbf set", fbf_q, 2);
        chk("R10 srq follows flag", srq_q, 2);
        @(negedge clk); host_flg_clr = 2'b10;
        @(negedge clk); host_flg_clr = 2'b00;
        chk("R10 data flag clear", {srq_q, fbf_q, flg_q}, 0);
        @(negedge clk); host_ctl_set = 2'b11;
        @(negedge clk); host_ctl_set = 2'b00;
        chk("R10 ctl set", ctl_q, 3);
        @(negedge clk); host_ctl_set = 2'b10; host_ctl_clr = 2'b10;
        @(negedge clk); host_ctl_set = 2'b00; host_ctl_clr = 2'b00;
        chk("R10 ctl clear wins", ctl_q, 1);
        chk("R10 data ctl clear drops xfer", xfer_en, 0);
        @(negedge clk); seq_first_clr = 1'b1;
        @(negedge clk); seq_first_clr = 1'b0;
        chk("R11 first cleared", first_svc, 0);
        unit_at_bot = 1'b0;
        pulse_done(4'b1000);
        chk("R8 done merges eof, busy drops", status_word, 9'o210);
        chk("R8 done sets cmd flag", flg_q, 1);
    endtask

    task automatic t_wlock;
        unit_wlock = 1'b1;
        put_code(8'o300);
        chk("R6 clear keeps bot only", status_word, 9'o004);
        chk("R6 clear drops flags and ctl", {ctl_q, flg_q}, 0);
        put_code(8'o031);
        chk("R3 write on locked unit", status_word, 9'o014);
        put_code(8'o300);
        put_code(8'o011);
        chk("R3 gap on locked unit", status_word, 9'o014);
        put_code(8'o300);
        put_code(8'o035);
        chk("R3 mark on locked unit", status_word, 9'o014);
        chk("R3 locked reject no first", first_svc, 0);
        unit_wlock = 1'b0;
        put_code(8'o300);
    endtask

    task automatic t_clear_rewind;
        int hits;
        put_code(8'o201);
        chk("R4 rewind accepted", status_word, 9'o001);
        @(negedge clk); host_ctl_set = 2'b11;
        @(negedge clk); host_ctl_set = 2'b00;
        idle(8);
        put_code(8'o300);
        chk("R7 clear aborts rewind", status_word, 9'o000);
        chk("R6 clear drops ctl", ctl_q, 0);
        count_go(45, hits);
        chk("R7 aborted rewind never starts", hits, 0);
    endtask

    task automatic t_clear_other;
        int k;
        put_code(8'o003);
        go_cycle(k);
        chk("R5 op_go cycle forward space", k, 40);
        put_code(8'o300);
        chk("R7 clear keeps forward space busy", status_word, 9'o001);
        chk("R6 clear drops first/xfer", {first_svc, xfer_en}, 0);
        pulse_done(4'b0011);
        chk("R8 done merges tim/par", status_word, 9'o022);
        chk("R8 done flag forward space", flg_q, 1);
    endtask

    task automatic t_rwoff_and_bot;
        int k;
        put_code(8'o101);
        chk("R4 accept clears cmd flag", flg_q, 0);
        go_cycle(k);
        unit_at_bot = 1'b1;
        pulse_done(4'b0000);
        chk("R8 rewind-offline no flag", flg_q, 0);
        chk("R8 rewind-offline loads bot", status_word, 9'o100);
        put_code(8'o041);
        chk("R3 backward space at bot", status_word, 9'o110);
        chk("R3 backward space func unchanged", func_q, 8'o101);
    endtask

    task automatic t_offline;
        int hits;
        put_code(8'o023);
        chk("R4 read accepted at bot", status_word, 9'o001);
        unit_attached = 1'b0;
        @(negedge clk);
        chk("R2 offline reads local and busy", status_word, 9'o401);
        count_go(45, hits);
        chk("R9 no op_go while offline", hits, 0);
        chk("R9 timeout rejects", status_word, 9'o411);
        chk("R9 timeout sets cmd flag", flg_q, 1);
        unit_attached = 1'b1;
        unit_wlock = 1'b1;
        @(negedge clk);
        chk("R2 live wlk and idle", status_word, 9'o014);
        unit_wlock = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_invalid();
        t_accept_read();
        t_wlock();
        t_clear_rewind();
        t_clear_other();
        t_rwoff_and_bot();
        t_offline();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule